// File: doc/BRIEF.md
# RTC Alarm and Periodic Interrupt Unit

This unit sits beside a real-time timekeeper and turns its outputs into interrupt events. On every update strobe from the timekeeper it compares the six current BCD time fields with six programmable alarm bytes. When all six match, it latches an alarm flag. It also watches the four rollover strobes (second, minute, hour, day). It records each of them in a sticky event flag and can raise a one-cycle periodic interrupt on the one that software selects.

Software reaches the unit through a byte-wide register port with a registered read path. Alarm and power-up flags in the status byte are cleared by writing 1 to them. The four rollover event flags clear when the status byte is read. A single interrupt line combines a level alarm request with the periodic pulse. The two sources have separate enables, so the periodic source can be masked while alarms still wake the system.

Top module: `rtc_alm_unit`

## Requirements
- R1: After reset, the status byte reads 0x80 (only the power-up flag, bit 7, set), the control byte at 0x0F reads 0x00, every alarm byte reads 0x00 and `irq` is low.
- R2: Alarm bytes are read/write at 0x07 to 0x0C in the order seconds, minutes, hours, day, month, year. At 0x0F, bits 3:0 are read/write and bits 7:4 read 0. Any other address except 0x0E reads 0x00.
- R3: The alarm flag (status bit 6) sets at the clock edge where `time_tick` is high and all six current fields equal the six alarm bytes. A mismatch in any one field, or no tick, leaves it clear.
- R4: Writing status with bit 6 or bit 7 at 1 clears the alarm or power-up flag. Writing 0 to those bits leaves them unchanged. An alarm match in the same cycle as the clear leaves the alarm flag set.
- R5: Status bits 2, 3, 4 and 5 are set by `roll_strb[0]`, `roll_strb[1]`, `roll_strb[2]` and `roll_strb[3]` (second, minute, hour, day). A status read returns their value before the read and clears them, except for a strobe arriving in the same cycle, which stays set.
- R6: While the alarm flag is set and control bit 3 is 1, `irq` stays high until the flag is cleared.
- R7: When control bit 2 is 1, the strobe `roll_strb[sel]` (sel = control bits 1:0, 0 = second, 1 = minute, 2 = hour, 3 = day) drives `irq` high for exactly the next cycle. With bit 2 at 0, or with any other strobe, no pulse occurs.
- R8: With control bit 2 at 0 and bit 3 at 1, a set alarm flag still drives `irq` high.
- R9: `bus_rdata` takes the addressed byte in the cycle after `bus_rd` is sampled high, and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| time_tick | input | 1 | Time fields were just updated; alarm compare strobe |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_day | input | 8 | Current day of month, BCD |
| cur_mon | input | 8 | Current month, BCD |
| cur_year | input | 8 | Current year, BCD |
| roll_strb | input | 4 | Rollover strobes: second, minute, hour, day |
| bus_addr | input | 5 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request |

## Verification
The embedded properties rely on `bus_rd`, `bus_wr`, `time_tick` and `roll_strb` being driven to known values at every clock edge, including during reset. They do not require the rollover strobes to be one-hot or to keep any particular spacing. The stimulus therefore drives every input on the falling edge, from the first cycle onward. It draws the strobes as independent random bits. It often copies the alarm bytes onto the time fields, so that matches, same-cycle set/clear collisions and reads colliding with strobes all happen frequently.

// File: rtl/rtc_alm_pkg.sv
package rtc_alm_pkg;

    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 5;
    localparam int N_FIELDS = 6;
    localparam int N_PERIOD = 4;
    localparam int SEL_W    = $clog2(N_PERIOD);

    localparam logic [ADDR_W-1:0] A_ALARM0 = 5'h07;
    localparam logic [ADDR_W-1:0] A_STATUS = 5'h0E;
    localparam logic [ADDR_W-1:0] A_ICTRL  = 5'h0F;

    typedef logic [DATA_W-1:0] byte_t;

    // status byte: {pwr, alm, ev[3:0], 2'b00}
    typedef struct packed {
        logic                pwr;
        logic                alm;
        logic [N_PERIOD-1:0] ev;
    } stat_t;

    // control byte low nibble: {alm_en, tmr_en, sel}
    typedef struct packed {
        logic             alm_en;
        logic             tmr_en;
        logic [SEL_W-1:0] sel;
    } ictl_t;

    function automatic byte_t stat_to_byte(stat_t s);
        return {s.pwr, s.alm, s.ev, 2'b00};
    endfunction

    function automatic byte_t ictl_to_byte(ictl_t c);
        return {{(DATA_W-$bits(ictl_t)){1'b0}}, c};
    endfunction

endpackage

// File: rtl/rtc_alm_regs.sv
module rtc_alm_regs
    import rtc_alm_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int NF = N_FIELDS
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr,
    input  logic [AW-1:0]          addr,
    input  logic [DW-1:0]          wdata,
    output logic [NF-1:0][DW-1:0]  alm_bytes,
    output ictl_t                  ictl
);

    genvar gi;
    generate
        for (gi = 0; gi < NF; gi++) begin : g_alm
            localparam logic [AW-1:0] MY_ADDR = A_ALARM0 + AW'(gi);
            always_ff @(posedge clk) begin
                if (rst)
                    alm_bytes[gi] <= '0;
                else if (wr && addr == MY_ADDR)
                    alm_bytes[gi] <= wdata;
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)
            ictl <= '0;
        else if (wr && addr == A_ICTRL)
            ictl <= ictl_t'(wdata[$bits(ictl_t)-1:0]);
    end

endmodule

// File: rtl/rtc_alm_cmp.sv
module rtc_alm_cmp
    import rtc_alm_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int NF = N_FIELDS
) (
    input  logic [NF-1:0][DW-1:0] cur,
    input  logic [NF-1:0][DW-1:0] alm,
    output logic                  match
);

    logic [NF-1:0] field_eq;

    genvar gi;
    generate
        for (gi = 0; gi < NF; gi++) begin : g_eq
            assign field_eq[gi] = (cur[gi] == alm[gi]);
        end
    endgenerate

    assign match = &field_eq;

endmodule

// File: rtl/rtc_alm_status.sv
module rtc_alm_status
    import rtc_alm_pkg::*;
#(
    parameter int NP = N_PERIOD
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          alm_set,
    input  logic [NP-1:0] roll,
    input  logic          rd_clr,
    input  logic          clr_alm,
    input  logic          clr_pwr,
    output stat_t         stat
);

    always_ff @(posedge clk) begin
        if (rst) begin
            stat.pwr <= 1'b1;
            stat.alm <= 1'b0;
            stat.ev  <= '0;
        end else begin
            stat.ev  <= (rd_clr ? '0 : stat.ev) | roll;
            stat.alm <= (stat.alm & ~clr_alm) | alm_set;
            stat.pwr <= stat.pwr & ~clr_pwr;
        end
    end

    // R3
    alm_sets_on_match_chk: assert property (@(posedge clk) disable iff (rst)
        alm_set |=> stat.alm);

    // R4
    alm_falls_on_w1c_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(stat.alm) |-> $past(clr_alm));

    // R4
    pwr_never_rises_chk: assert property (@(posedge clk) disable iff (rst)
        !$rose(stat.pwr));

    // R5
    ev_cleared_by_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_clr && roll == '0) |=> stat.ev == '0);

endmodule

// File: rtl/rtc_alm_irq.sv
module rtc_alm_irq
    import rtc_alm_pkg::*;
#(
    parameter int NP = N_PERIOD
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NP-1:0] roll,
    input  ictl_t         ictl,
    input  logic          alm_flag,
    output logic          irq
);

    logic tmr_q;

    always_ff @(posedge clk) begin
        if (rst)
            tmr_q <= 1'b0;
        else
            tmr_q <= ictl.tmr_en & roll[ictl.sel];
    end

    assign irq = tmr_q | (alm_flag & ictl.alm_en);

    // R7
    tmr_pulse_follows_chk: assert property (@(posedge clk) disable iff (rst)
        (ictl.tmr_en && roll[ictl.sel]) |=> irq);

    // R7
    tmr_pulse_absent_chk: assert property (@(posedge clk) disable iff (rst)
        !(ictl.tmr_en && roll[ictl.sel]) |=> (irq == (alm_flag && ictl.alm_en)));

endmodule

// File: rtl/rtc_alm_unit.sv
module rtc_alm_unit
    import rtc_alm_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W,
    parameter int NF = N_FIELDS,
    parameter int NP = N_PERIOD
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          time_tick,
    input  logic [7:0]    cur_sec,
    input  logic [7:0]    cur_min,
    input  logic [7:0]    cur_hour,
    input  logic [7:0]    cur_day,
    input  logic [7:0]    cur_mon,
    input  logic [7:0]    cur_year,
    input  logic [NP-1:0] roll_strb,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic          bus_rd,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    output logic          irq
);

    logic [NF-1:0][DW-1:0] cur_fields;
    logic [NF-1:0][DW-1:0] alm_bytes;
    ictl_t                 ictl;
    stat_t                 stat;
    logic                  match;
    logic                  stat_wr;
    logic                  stat_rd;
    logic [DW-1:0]         rd_val;

    assign cur_fields = {cur_year, cur_mon, cur_day, cur_hour, cur_min, cur_sec};
    assign stat_wr    = bus_wr && bus_addr == A_STATUS;
    assign stat_rd    = bus_rd && bus_addr == A_STATUS;

    rtc_alm_regs #(.DW(DW), .AW(AW), .NF(NF)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr        (bus_wr),
        .addr      (bus_addr),
        .wdata     (bus_wdata),
        .alm_bytes (alm_bytes),
        .ictl      (ictl)
    );

    rtc_alm_cmp #(.DW(DW), .NF(NF)) u_cmp (
        .cur   (cur_fields),
        .alm   (alm_bytes),
        .match (match)
    );

    rtc_alm_status #(.NP(NP)) u_status (
        .clk     (clk),
        .rst     (rst),
        .alm_set (time_tick & match),
        .roll    (roll_strb),
        .rd_clr  (stat_rd),
        .clr_alm (stat_wr & bus_wdata[DW-2]),
        .clr_pwr (stat_wr & bus_wdata[DW-1]),
        .stat    (stat)
    );

    rtc_alm_irq #(.NP(NP)) u_irq (
        .clk      (clk),
        .rst      (rst),
        .roll     (roll_strb),
        .ictl     (ictl),
        .alm_flag (stat.alm),
        .irq      (irq)
    );

    always_comb begin
        rd_val = '0;
        if (bus_addr == A_STATUS)
            rd_val = stat_to_byte(stat);
        else if (bus_addr == A_ICTRL)
            rd_val = ictl_to_byte(ictl);
        else
            for (int i = 0; i < NF; i++)
                if (bus_addr == A_ALARM0 + AW'(i))
                    rd_val = alm_bytes[i];
    end

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else if (bus_rd)
            bus_rdata <= rd_val;
    end

    // R6 R8
    alm_level_irq_chk: assert property (@(posedge clk) disable iff (rst)
        (stat.alm && ictl.alm_en) |-> irq);

    // R9
    rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

endmodule

// File: tb/rtc_alm_unit_tb.sv
`timescale 1ns/1ps
module rtc_alm_unit_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       time_tick = 1'b0;
    logic [7:0] cur [6];
    logic [3:0] roll_strb = '0;
    logic [4:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;

    int checks = 0;
    int failures = 0;

    // reference model state
    logic [7:0] m_alm [6];
    logic [3:0] m_ictl;
    logic [3:0] m_ev;
    logic       m_af, m_pf, m_tmr;
    logic [7:0] m_rdata;

    always #4 clk = ~clk;

    rtc_alm_unit u_dut (
        .clk(clk), .rst(rst), .time_tick(time_tick),
        .cur_sec(cur[0]), .cur_min(cur[1]), .cur_hour(cur[2]),
        .cur_day(cur[3]), .cur_mon(cur[4]), .cur_year(cur[5]),
        .roll_strb(roll_strb), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq(irq)
    );

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] model_read(input logic [4:0] a);
        if (a == 5'h0E) return {m_pf, m_af, m_ev, 2'b00};
        if (a == 5'h0F) return {4'h0, m_ictl};
        if (a >= 5'h07 && a <= 5'h0C) return m_alm[a - 5'h07];
        return 8'h00;
    endfunction

    // advance one clock, update the model from the driven inputs, check irq and rdata
    task automatic step();
        logic match;
        logic stw;
        match = time_tick;
        for (int i = 0; i < 6; i++) if (cur[i] !== m_alm[i]) match = 1'b0;
        stw = bus_wr && bus_addr == 5'h0E;
        if (bus_rd) m_rdata = model_read(bus_addr);
        m_tmr = m_ictl[2] & roll_strb[m_ictl[1:0]];
        m_ev  = ((bus_rd && bus_addr == 5'h0E) ? 4'h0 : m_ev) | roll_strb;
        m_af  = (m_af & ~(stw & bus_wdata[6])) | match;
        m_pf  = m_pf & ~(stw & bus_wdata[7]);
        if (bus_wr && bus_addr == 5'h0F) m_ictl = bus_wdata[3:0];
        if (bus_wr && bus_addr >= 5'h07 && bus_addr <= 5'h0C) m_alm[bus_addr - 5'h07] = bus_wdata;
        @(posedge clk);
        @(negedge clk);
        chk({7'h0, irq}, {7'h0, m_tmr | (m_af & m_ictl[3])}, "R6 R7 irq");
        chk(bus_rdata, m_rdata, "R9 rdata");
    endtask

    task automatic idle();
        bus_wr = 0; bus_rd = 0; time_tick = 0; roll_strb = '0;
    endtask

    task automatic do_wr(input logic [4:0] a, input logic [7:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1; bus_rd = 0;
        step();
        bus_wr = 0;
    endtask

    task automatic do_rd(input logic [4:0] a, output logic [7:0] d);
        bus_addr = a; bus_rd = 1; bus_wr = 0;
        step();
        bus_rd = 0;
        d = bus_rdata;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [7:0] av [6];
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 6; i++) cur[i] = 8'h00;
        cur[0] = 8'h01;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        for (int i = 0; i < 6; i++) m_alm[i] = 8'h00;
        m_ictl = 0; m_ev = 0; m_af = 0; m_pf = 1; m_tmr = 0; m_rdata = 0;

        // R1 reset state
        chk({7'h0, irq}, 8'h00, "R1 irq");
        do_rd(5'h0E, d); chk(d, 8'h80, "R1 status");
        do_rd(5'h0F, d); chk(d, 8'h00, "R1 ictrl");
        do_rd(5'h07, d); chk(d, 8'h00, "R1 alarm");

        // R2 register access
        av = '{8'h30, 8'h15, 8'h09, 8'h21, 8'h06, 8'h25};
        for (int i = 0; i < 6; i++) do_wr(5'h07 + 5'(i), av[i]);
        for (int i = 0; i < 6; i++) begin
            do_rd(5'h07 + 5'(i), d); chk(d, av[i], "R2 alarm byte");
        end
        do_wr(5'h0F, 8'hFF);
        do_rd(5'h0F, d); chk(d, 8'h0F, "R2 ictrl");
        do_wr(5'h0F, 8'h00);
        do_rd(5'h0D, d); chk(d, 8'h00, "R2 unmapped");
        do_rd(5'h00, d); chk(d, 8'h00, "R2 unmapped");
        // R9 hold
        step(); step(); chk(bus_rdata, 8'h00, "R9 hold");

        // R4 write 0 ignored, write 1 clears
        do_wr(5'h0E, 8'h00);
        do_rd(5'h0E, d); chk(d, 8'h80, "R4 write0 keeps pwr");
        do_wr(5'h0E, 8'h80);
        do_rd(5'h0E, d); chk(d, 8'h00, "R4 w1c pwr");

        // R5 sticky events, clear on read, same-cycle strobe kept
        roll_strb = 4'b0101; step(); roll_strb = 0;
        do_rd(5'h0E, d); chk(d, 8'h14, "R5 events");
        do_rd(5'h0E, d); chk(d, 8'h00, "R5 clear on read");
        roll_strb = 4'b1000; bus_addr = 5'h0E; bus_rd = 1; step(); idle();
        do_rd(5'h0E, d); chk(d, 8'h20, "R5 strobe during read kept");
        do_rd(5'h0E, d);

        // R3 alarm compare
        for (int i = 0; i < 6; i++) cur[i] = av[i];
        step();
        do_rd(5'h0E, d); chk(d, 8'h00, "R3 no tick no alarm");
        cur[4] = 8'h07; time_tick = 1; step(); time_tick = 0;
        do_rd(5'h0E, d); chk(d, 8'h00, "R3 one field off");
        cur[4] = 8'h06; time_tick = 1; step(); time_tick = 0;
        do_rd(5'h0E, d); chk(d, 8'h40, "R3 match sets alarm");

        // R8 R6 alarm irq with timer masked
        do_wr(5'h0F, 8'h08);
        chk({7'h0, irq}, 8'h01, "R8 alarm irq with timer masked");
        roll_strb = 4'hF; step(); idle(); step();
        chk({7'h0, irq}, 8'h01, "R6 level held");
        // R4 set wins over clear in same cycle
        time_tick = 1; bus_addr = 5'h0E; bus_wdata = 8'h40; bus_wr = 1; step(); idle();
        chk({7'h0, irq}, 8'h01, "R4 set beats clear");
        do_wr(5'h0E, 8'h40);
        chk({7'h0, irq}, 8'h00, "R6 irq drops on clear");

        // R7 periodic select
        for (int s = 0; s < 4; s++) begin
            do_wr(5'h0F, 8'h04 | 8'(s));
            roll_strb = 4'(1 << ((s + 1) % 4)); step(); idle();
            chk({7'h0, irq}, 8'h00, "R7 other strobe no pulse");
            roll_strb = 4'(1 << s); step(); idle();
            chk({7'h0, irq}, 8'h01, "R7 selected pulse");
            step();
            chk({7'h0, irq}, 8'h00, "R7 pulse one cycle");
        end
        do_wr(5'h0F, 8'h00);
        roll_strb = 4'hF; step(); idle();
        chk({7'h0, irq}, 8'h00, "R7 timer disabled");
        do_rd(5'h0E, d);

        // random mix
        for (int n = 0; n < 4000; n++) begin
            int op;
            for (int i = 0; i < 6; i++)
                cur[i] = ($urandom_range(3) != 0) ? m_alm[i] : 8'($urandom_range(3));
            time_tick = ($urandom_range(2) == 0);
            roll_strb = 4'($urandom_range(15)) & 4'($urandom_range(15)) & 4'($urandom_range(15));
            op = $urandom_range(7);
            case ($urandom_range(4))
                0: bus_addr = 5'h0E;
                1: bus_addr = 5'h0F;
                2: bus_addr = 5'($urandom_range(31));
                default: bus_addr = 5'h07 + 5'($urandom_range(5));
            endcase
            bus_wdata = (bus_addr >= 5'h07 && bus_addr <= 5'h0C) ? 8'($urandom_range(3))
                                                                 : 8'($urandom_range(255));
            bus_wr = (op < 2);
            bus_rd = (op >= 2 && op < 5);
            step();
        end
        idle();
        step();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule